// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from a set of peripheral sources and chooses which one, if any, the processor should service next. Each source owns a sticky pending flag, an enable bit and a three-bit priority level. The block chooses the best candidate: the highest level among sources that are pending, enabled and non-zero, with the lowest source index breaking ties. It raises a request only when that level is strictly above the processor's current priority. With the request it presents the handler's vector address, the source index and the level the processor would run at.

The processor answers a request with a one-cycle acknowledge. The block then saves the current processor priority on an internal stack and raises the priority to the winner's level. A one-cycle return input restores the saved value. A control register chooses between a primary and an alternate vector table and can forbid preemption of a running handler. Software reaches the flags, enables, priorities, control bits and the processor priority through a simple word-wide register port. Pending flags are never cleared by hardware.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset every flag, enable and priority field is 0, the control word is 0, `cpu_prio` is 0, the stack is empty and `irq_req` is low.
- R2: A high `src_irq[i]` sets flag i, which is readable at address 2+i/16, bit i%16. The flag stays set until software writes 0 to that bit. Hardware never clears it.
- R3: A source is a candidate only when its flag is 1, its enable is 1 and its priority is non-zero. Enable i sits at address 6+i/16, bit i%16. Priority i sits at address 10+i/4, bits 4*(i%4)+2 down to 4*(i%4).
- R4: Among candidates the highest priority wins. When levels are equal, the lowest source index wins. `irq_id` and `irq_lvl` report the winner.
- R5: `irq_req` is high only when the winner's level is strictly greater than `cpu_prio`. `cpu_prio` is written at address 1, bits 2:0.
- R6: `irq_vec` equals the table base plus 2 times `irq_id`. The base is 0x000004 when control bit 0 (address 0) is 0 and 0x000084 when it is 1.
- R7: An `irq_ack` while `irq_req` is high, without `irq_ret`, pushes `cpu_prio` and sets `cpu_prio` to `irq_lvl` on the next cycle.
- R8: An `irq_ret` with a non-empty stack restores the last pushed priority on the next cycle. An `irq_ret` with an empty stack leaves `cpu_prio` unchanged. `irq_ret` takes precedence over a simultaneous `irq_ack`.
- R9: When control bit 1 is set and the stack is not empty, `irq_req` stays low whatever is pending.
- R10: Writing 7 to `cpu_prio` inside a handler blocks every source, including level-7 ones.
- R11: With 8 entries on the stack, `irq_req` stays low. After one return it may rise again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | 54 | Per-source request; high sets the pending flag |
| irq_ack | input | 1 | Processor accepts the current request |
| irq_ret | input | 1 | Processor leaves a handler |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | 24 | Handler vector word address |
| irq_id | output | 6 | Winning source index |
| irq_lvl | output | 3 | Winning priority level |
| cpu_prio | output | 3 | Current processor priority |

## Verification
The bench builds the block with its default parameters: 54 sources, 16-bit register words, a 24-bit vector and an 8-deep stack. These values reach source 53 in the partly filled last flag and enable words and in the half-used last priority word. They also reach both ends of each table. An 8-deep stack is small enough that the bench can fill it with eight acknowledges and observe the request being held off.

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
  parameter int NUM_SRC     = 54,
  parameter int DATA_W      = 16,
  parameter int VEC_W       = 24,
  parameter int STACK_DEPTH = 8,
  parameter logic [VEC_W-1:0] PRI_BASE = 'h000004,
  parameter logic [VEC_W-1:0] ALT_BASE = 'h000084,
  localparam int FW    = (NUM_SRC + DATA_W - 1) / DATA_W,
  localparam int PPW   = DATA_W / 4,
  localparam int PW    = (NUM_SRC + PPW - 1) / PPW,
  localparam int A_FLG = 2,
  localparam int A_EN  = A_FLG + FW,
  localparam int A_PRI = A_EN + FW,
  localparam int NREG  = A_PRI + PW,
  localparam int AW    = $clog2(NREG),
  localparam int IDW   = $clog2(NUM_SRC),
  localparam int SW    = $clog2(STACK_DEPTH),
  localparam int DW    = $clog2(STACK_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic               irq_ack,
  input  logic               irq_ret,
  input  logic               reg_wr,
  input  logic [AW-1:0]      reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vec,
  output logic [IDW-1:0]     irq_id,
  output logic [2:0]         irq_lvl,
  output logic [2:0]         cpu_prio
);

  logic [NUM_SRC-1:0] flags, en;
  logic [2:0]         prio [NUM_SRC];
  logic [2:0]         stk  [STACK_DEPTH];
  logic [DW-1:0]      depth;
  logic               alt_sel, nest_off;
  logic [2:0]         best_lvl;
  logic [IDW-1:0]     best_id;

  wire busy = depth != '0;
  wire full = depth == DW'(STACK_DEPTH);
  wire [SW-1:0] push_idx = depth[SW-1:0];
  wire [SW-1:0] pop_idx  = depth[SW-1:0] - 1'b1;
  wire pop  = irq_ret && busy;
  wire take = irq_ack && irq_req && !irq_ret;

  always_comb begin
    best_lvl = '0;
    best_id  = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (flags[i] && en[i] && prio[i] > best_lvl) begin
        best_lvl = prio[i];
        best_id  = IDW'(i);
      end
  end

  assign irq_lvl = best_lvl;
  assign irq_id  = best_id;
  assign irq_req = (best_lvl > cpu_prio) && !full && !(nest_off && busy);
  assign irq_vec = (alt_sel ? ALT_BASE : PRI_BASE) + VEC_W'({best_id, 1'b0});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flags <= '0;
      en    <= '0;
      for (int i = 0; i < NUM_SRC; i++) prio[i] <= '0;
    end else
      for (int i = 0; i < NUM_SRC; i++) begin
        if (reg_wr && reg_addr == AW'(A_FLG + i / DATA_W))
          flags[i] <= reg_wdata[i % DATA_W] | src_irq[i];
        else if (src_irq[i])
          flags[i] <= 1'b1;
        if (reg_wr && reg_addr == AW'(A_EN + i / DATA_W))
          en[i] <= reg_wdata[i % DATA_W];
        if (reg_wr && reg_addr == AW'(A_PRI + i / PPW))
          prio[i] <= reg_wdata[(i % PPW) * 4 +: 3];
      end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      alt_sel  <= 1'b0;
      nest_off <= 1'b0;
    end else if (reg_wr && reg_addr == '0) begin
      alt_sel  <= reg_wdata[0];
      nest_off <= reg_wdata[1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cpu_prio <= '0;
      depth    <= '0;
    end else if (pop) begin
      cpu_prio <= stk[pop_idx];
      depth    <= depth - 1'b1;
    end else if (take) begin
      stk[push_idx] <= cpu_prio;
      cpu_prio      <= best_lvl;
      depth         <= depth + 1'b1;
    end else if (reg_wr && reg_addr == AW'(1)) begin
      cpu_prio <= reg_wdata[2:0];
    end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) reg_rdata[1:0] = {nest_off, alt_sel};
    if (reg_addr == AW'(1)) reg_rdata[2:0] = cpu_prio;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (reg_addr == AW'(A_FLG + i / DATA_W)) reg_rdata[i % DATA_W] = flags[i];
      if (reg_addr == AW'(A_EN + i / DATA_W))  reg_rdata[i % DATA_W] = en[i];
      if (reg_addr == AW'(A_PRI + i / PPW))    reg_rdata[(i % PPW) * 4 +: 3] = prio[i];
    end
  end

  p_req_above_cpu_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_lvl > cpu_prio) && (irq_lvl != '0));

  p_ack_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && !irq_ret) |=> cpu_prio == $past(irq_lvl));

  p_ret_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && depth != '0) |=> depth == $past(depth) - 1'b1);

  p_nest_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (nest_off && depth != '0) |-> !irq_req);

  p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr >= AW'(A_FLG) && reg_addr < AW'(A_EN))
      |=> (flags & $past(flags)) == $past(flags));

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (depth == DW'(STACK_DEPTH)) |-> !irq_req);

endmodule

// File: tb/test_prio_vec_intc.sv
module test_prio_vec_intc;
  localparam int N = 54;

  logic        clk = 0, rst_n = 0;
  logic [N-1:0] src_irq = '0;
  logic        irq_ack = 0, irq_ret = 0, reg_wr = 0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        irq_req;
  logic [23:0] irq_vec;
  logic [5:0]  irq_id;
  logic [2:0]  irq_lvl, cpu_prio;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [2:0] psh [N];
  logic [N-1:0] ensh;

  always #2 clk = ~clk;

  prio_vec_intc i_prio_vec_intc (
    .clk, .rst_n, .src_irq, .irq_ack, .irq_ret, .reg_wr, .reg_addr,
    .reg_wdata, .reg_rdata, .irq_req, .irq_vec, .irq_id, .irq_lvl, .cpu_prio);

  // fields: a_id, a_lvl, b_id, b_lvl, cpu, alt, exp_req, exp_id
  localparam logic [28:0] TBL [8] = '{
    {6'd5,  3'd3, 6'd9,  3'd3, 3'd0, 1'b0, 1'b1, 6'd5},
    {6'd40, 3'd6, 6'd2,  3'd2, 3'd0, 1'b0, 1'b1, 6'd40},
    {6'd53, 3'd7, 6'd0,  3'd7, 3'd0, 1'b1, 1'b1, 6'd0},
    {6'd10, 3'd4, 6'd11, 3'd4, 3'd4, 1'b0, 1'b0, 6'd0},
    {6'd10, 3'd5, 6'd11, 3'd4, 3'd4, 1'b0, 1'b1, 6'd10},
    {6'd20, 3'd0, 6'd21, 3'd1, 3'd0, 1'b0, 1'b1, 6'd21},
    {6'd53, 3'd2, 6'd52, 3'd2, 3'd0, 1'b1, 1'b1, 6'd52},
    {6'd30, 3'd1, 6'd31, 3'd1, 3'd1, 1'b0, 1'b0, 6'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic set_prio(input int s, input int l);
    logic [15:0] d = '0;
    int w = s / 4;
    psh[s] = 3'(l);
    for (int j = 0; j < 4; j++) if (4*w + j < N) d[4*j +: 3] = psh[4*w + j];
    wr(5'(10 + w), d);
  endtask

  task automatic set_en(input int s, input bit v);
    logic [15:0] d = '0;
    int w = s / 16;
    ensh[s] = v;
    for (int j = 0; j < 16; j++) if (16*w + j < N) d[j] = ensh[16*w + j];
    wr(5'(6 + w), d);
  endtask

  task automatic pulse(input int s);
    @(negedge clk); src_irq[s] = 1'b1;
    @(negedge clk); src_irq = '0;
  endtask

  task automatic ack;
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
  endtask

  task automatic ret;
    @(negedge clk); irq_ret = 1;
    @(negedge clk); irq_ret = 0;
  endtask

  task automatic arm(input int s, input int l);
    set_prio(s, l); set_en(s, 1); pulse(s);
  endtask

  task automatic clear_all;
    src_irq = '0;
    for (int k = 0; k < 8; k++) ret;
    for (int a = 0; a < 24; a++) wr(5'(a), 16'h0);
    for (int s = 0; s < N; s++) psh[s] = '0;
    ensh = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    for (int s = 0; s < N; s++) psh[s] = '0;
    ensh = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 req", irq_req, 0);
    chk("R1 cpu_prio", cpu_prio, 0);
    rd(5'd0, d);  chk("R1 control", d, 0);
    rd(5'd2, d);  chk("R1 flags", d, 0);
    rd(5'd9, d);  chk("R1 enables", d, 0);
    rd(5'd23, d); chk("R1 priority", d, 0);

    // table-driven arbitration: R3 R4 R5 R6
    foreach (TBL[e]) begin
      logic [28:0] t = TBL[e];
      clear_all;
      arm(t[28:23], t[22:20]);
      arm(t[19:14], t[13:11]);
      if (t[10:8] != 0) wr(5'd1, {13'd0, t[10:8]});
      wr(5'd0, {15'd0, t[7]});
      #1;
      chk($sformatf("R4 R5 table %0d req", e), irq_req, t[6]);
      if (t[6]) begin
        chk($sformatf("R4 table %0d id", e), irq_id, t[5:0]);
        chk($sformatf("R6 table %0d vec", e), irq_vec,
            (t[7] ? 24'h84 : 24'h04) + 2 * t[5:0]);
      end
    end

    // R2 sticky flag and software clear
    clear_all;
    pulse(17);
    rd(5'd3, d); chk("R2 flag set", d[1], 1);
    repeat (5) @(negedge clk);
    rd(5'd3, d); chk("R2 flag held", d[1], 1);
    wr(5'd3, 16'h0);
    rd(5'd3, d); chk("R2 flag cleared", d[1], 0);

    // R3 enable gating
    set_prio(17, 4); pulse(17); #1;
    chk("R3 disabled source", irq_req, 0);
    set_en(17, 1); #1;
    chk("R3 enabled source req", irq_req, 1);
    chk("R3 enabled source id", irq_id, 17);

    // R7 R8 nesting, preemption and return
    clear_all;
    arm(3, 2); #1;
    chk("R7 req before ack", irq_req, 1);
    ack; #1;
    chk("R7 cpu raised", cpu_prio, 2);
    chk("R5 no self-retake", irq_req, 0);
    arm(8, 5); #1;
    chk("R7 preempt req", irq_req, 1);
    chk("R7 preempt id", irq_id, 8);
    ack; #1;
    chk("R7 cpu raised nested", cpu_prio, 5);
    ret; #1;
    chk("R8 pop to outer", cpu_prio, 2);
    ret; #1;
    chk("R8 pop to base", cpu_prio, 0);
    wr(5'd1, 16'd3);
    ret; #1;
    chk("R8 empty return ignored", cpu_prio, 3);
    // ret precedence over ack
    wr(5'd1, 16'd0);
    @(negedge clk); irq_ack = 1; irq_ret = 1;
    @(negedge clk); irq_ack = 0; irq_ret = 0; #1;
    chk("R8 ret beats ack", cpu_prio, 0);

    // R9 nesting disabled
    clear_all;
    wr(5'd0, 16'h2);
    arm(3, 2);
    ack;
    arm(8, 5); #1;
    chk("R9 nest blocked", irq_req, 0);
    ret; #1;
    chk("R9 req after return", irq_req, 1);

    // R10 software raises cpu_prio to 7
    clear_all;
    arm(4, 6);
    ack;
    wr(5'd1, 16'd7);
    arm(5, 7); #1;
    chk("R10 level 7 blocked", irq_req, 0);
    rd(5'd1, d); chk("R10 cpu readback", d[2:0], 7);

    // R11 stack full
    clear_all;
    arm(1, 1);
    for (int k = 0; k < 8; k++) begin
      ack;
      wr(5'd1, 16'd0);
    end
    #1;
    chk("R11 full blocks req", irq_req, 0);
    ret; #1;
    chk("R11 req after pop", irq_req, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule